// File: doc/BRIEF.md
# Paged Transmit Record Walker

This block pulls outgoing frame records out of a host-filled transmit area in memory and hands them, one 32-bit word at a time, to a downstream frame consumer. The host writes records into 2 KB pages, each page starting on a 2 KB boundary, and joins the pages with in-band link records. Each record starts on a 4-byte boundary. Its first word holds a 16-bit little-endian byte size in the low half and a 16-bit record type in the high half. The walker follows the chain in memory. It forwards frame records and absorbs link records. For each link record it absorbs, it raises a one-cycle event, which the host uses to reclaim a page.

Work arrives through a doorbell. Each pulse means that one more frame is ready in memory. The walker keeps a count of frames not yet delivered and stops before any record header when that count is zero. The start address is loaded as two 32-bit halves while the engine is held by its hold input. Fetching starts from that address once the hold is released. Asserting the hold again aborts the fetch in progress and discards the count of waiting frames.

Top module: `txw_walker`

## Requirements
- R1: After reset, `frm_valid`, `rd_req` and `link_evt` are low. With the hold released and no doorbell pulse, no read is issued.
- R2: `base_lo_we` loads the low 32 bits of the start address and `base_hi_we` loads the high 32 bits, both from `cfg_wdata`. Bits 1:0 of the address are forced to zero. The first read after the hold is released goes to this address.
- R3: Each cycle with `doorbell` high and hold low adds one frame to the waiting count. While that count is zero, `rd_req` and `frm_valid` stay low.
- R4: Bits 15:0 of a header word give the record's byte size and bits 31:16 give its type. A frame record is delivered as max(1, ceil(size/4)) words in memory order. The header word itself is the first word and carries `frm_first`, and the final word carries `frm_last`.
- R5: The record after a frame starts at the frame's start address plus 4*max(1, ceil(size/4)). Consecutive words of one record are read at increasing addresses 4 bytes apart.
- R6: A record of type 0x1001 is a link of three words: the header, then the low 32 bits of the next address, then the high 32 bits. None of its words reaches the frame output. Fetching continues at the next address with bits 1:0 cleared, and `link_evt` is high for exactly one cycle.
- R7: A link record does not use up a waiting frame. Every rung frame is still delivered after any number of links.
- R8: The waiting count drops by one when a word with `frm_last` is accepted. A doorbell pulse in that same cycle leaves the count unchanged.
- R9: While `frm_valid` is high and `frm_ready` is low, `frm_data`, `frm_first` and `frm_last` hold their values and no new read is issued.
- R10: One cycle after `hold` goes high, `frm_valid` and `rd_req` are low. The waiting count is cleared, and a read response arriving afterwards is ignored.
- R11: At most one read is outstanding. After a read request is accepted, `rd_req` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Holds the engine idle; releasing it starts fetching at the start address |
| base_lo_we | input | 1 | Load the low half of the start address from `cfg_wdata` |
| base_hi_we | input | 1 | Load the high half of the start address from `cfg_wdata` |
| cfg_wdata | input | 32 | Write data for the start address halves |
| doorbell | input | 1 | One pulse for each frame the host has finished writing |
| rd_req | output | 1 | Memory word read request |
| rd_ready | input | 1 | Memory accepts the request this cycle |
| rd_addr | output | 64 | Byte address of the requested word (bits 1:0 zero) |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| frm_valid | output | 1 | Frame word available to the consumer |
| frm_ready | input | 1 | Consumer takes the word this cycle |
| frm_data | output | 32 | Frame word |
| frm_first | output | 1 | Word is the record header |
| frm_last | output | 1 | Word is the final word of the record |
| link_evt | output | 1 | One-cycle pulse for each link record absorbed |

## Verification
Two events can fall in the same cycle: a doorbell pulse and acceptance of a frame's final word. Only their net effect on the waiting count is visible. The bench provokes this by holding back `frm_ready` until a final word is on the output, then asserting `frm_ready` and pulsing `doorbell` in the same cycle. A reference count in the bench adds doorbells and subtracts delivered frames on every clock. In the cycle after its count reaches zero, the walker must be quiet on both the read port and the frame port. If the walker lost the increment or applied it twice, it would either leave a rung frame undelivered or read past the last one.

// File: rtl/txw_pkg.sv
package txw_pkg;

  typedef enum logic [1:0] {
    W_IDLE,
    W_REQ,
    W_WAIT,
    W_OUT
  } walk_st_e;

  // Number of 32-bit words a record of sz bytes occupies (never zero).
  function automatic logic [14:0] words_of(input logic [15:0] sz);
    logic [16:0] t;
    t = {1'b0, sz} + 17'd3;
    return (t[16:2] == 15'd0) ? 15'd1 : t[16:2];
  endfunction

endpackage

// File: rtl/txw_base_regs.sv
module txw_base_regs #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [31:0]   wdata,
  output logic [AW-1:0] base
);
  localparam int HI_W = AW - 32;

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      if (lo_we) base_q[31:0]    <= {wdata[31:2], 2'b00};
      if (hi_we) base_q[AW-1:32] <= wdata[HI_W-1:0];
    end
  end

  assign base = base_q;

  p_base_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    lo_we |=> (base[1:0] == 2'b00));

endmodule

// File: rtl/txw_pend_ctr.sv
module txw_pend_ctr #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  output logic nz
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt != CMAX) cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign nz = (cnt != '0);

  // R8: simultaneous doorbell and frame completion cancel out
  p_net_zero_r8: assert property (@(posedge clk) disable iff (rst || clr)
    (inc && dec) |=> $stable(cnt));

  // R8: a completion is only ever seen while work is counted
  p_dec_live_r8: assert property (@(posedge clk) disable iff (rst || clr)
    dec |-> nz);

endmodule

// File: rtl/txw_seq.sv
module txw_seq
  import txw_pkg::*;
#(
  parameter int          AW        = 64,
  parameter logic [15:0] LINK_TYPE = 16'h1001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] base,
  input  logic          pend_nz,
  output logic          rd_req,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  output logic          frm_valid,
  input  logic          frm_ready,
  output logic [31:0]   frm_data,
  output logic          frm_first,
  output logic          frm_last,
  output logic          link_evt,
  output logic          frame_done,
  output logic          hdr_fetch
);
  localparam int          HI_W  = AW - 32;
  localparam logic [AW-1:0] STEP = AW'(4);

  walk_st_e      st;
  logic [AW-1:0] addr_q;
  logic [14:0]   widx;
  logic [14:0]   nwords;
  logic          in_link;
  logic [31:0]   link_lo;
  logic [31:0]   dat_q;
  logic          first_q;
  logic          last_q;
  logic          link_q;
  logic [14:0]   hdr_words;

  assign hdr_words = words_of(rsp_data[15:0]);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st      <= W_IDLE;
      addr_q  <= base;
      widx    <= '0;
      nwords  <= 15'd1;
      in_link <= 1'b0;
      link_lo <= '0;
      dat_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      link_q <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (pend_nz) begin
            st      <= W_REQ;
            widx    <= '0;
            in_link <= 1'b0;
          end
        end
        W_REQ: begin
          if (rd_ready) st <= W_WAIT;
        end
        W_WAIT: begin
          if (rsp_valid) begin
            if (in_link) begin
              if (widx == 15'd1) begin
                link_lo <= rsp_data;
                widx    <= 15'd2;
                addr_q  <= addr_q + STEP;
                st      <= W_REQ;
              end else begin
                addr_q  <= {rsp_data[HI_W-1:0], link_lo[31:2], 2'b00};
                link_q  <= 1'b1;
                in_link <= 1'b0;
                st      <= W_IDLE;
              end
            end else if (widx == '0 && rsp_data[31:16] == LINK_TYPE) begin
              in_link <= 1'b1;
              widx    <= 15'd1;
              addr_q  <= addr_q + STEP;
              st      <= W_REQ;
            end else begin
              dat_q   <= rsp_data;
              first_q <= (widx == '0);
              if (widx == '0) begin
                nwords <= hdr_words;
                last_q <= (hdr_words == 15'd1);
              end else begin
                last_q <= (widx + 15'd1 == nwords);
              end
              st <= W_OUT;
            end
          end
        end
        W_OUT: begin
          if (frm_ready) begin
            addr_q <= addr_q + STEP;
            if (last_q) begin
              st <= W_IDLE;
            end else begin
              widx <= widx + 15'd1;
              st   <= W_REQ;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign rd_req     = (st == W_REQ);
  assign rd_addr    = addr_q;
  assign frm_valid  = (st == W_OUT);
  assign frm_data   = dat_q;
  assign frm_first  = first_q;
  assign frm_last   = last_q;
  assign link_evt   = link_q;
  assign frame_done = (st == W_OUT) && frm_ready && last_q;
  assign hdr_fetch  = (st == W_REQ) && (widx == '0) && !in_link;

  // R11: a single read in flight
  p_one_out_r11: assert property (@(posedge clk) disable iff (rst || hold)
    (rd_req && rd_ready) |=> !rd_req);

  // R9: output word held under back-pressure, no new read meanwhile
  p_stall_r9: assert property (@(posedge clk) disable iff (rst || hold)
    (frm_valid && !frm_ready) |=> (frm_valid && !rd_req && $stable(frm_data)
                                   && $stable(frm_last) && $stable(frm_first)));

  // R10: hold quiets both ports within one cycle
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!frm_valid && !rd_req));

  // R6: link event is a single-cycle pulse
  p_link_pulse_r6: assert property (@(posedge clk) disable iff (rst || hold)
    link_evt |=> !link_evt);

  // R6: a link is never accompanied by a frame word on the output
  p_link_quiet_r6: assert property (@(posedge clk) disable iff (rst || hold)
    link_evt |-> !frm_valid);

endmodule

// File: rtl/txw_walker.sv
module txw_walker #(
  parameter int          AW        = 64,
  parameter int          PEND_W    = 8,
  parameter logic [15:0] LINK_TYPE = 16'h1001
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          base_lo_we,
  input  logic          base_hi_we,
  input  logic [31:0]   cfg_wdata,
  input  logic          doorbell,
  output logic          rd_req,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [31:0]   rsp_data,
  output logic          frm_valid,
  input  logic          frm_ready,
  output logic [31:0]   frm_data,
  output logic          frm_first,
  output logic          frm_last,
  output logic          link_evt
);
  logic [AW-1:0] base;
  logic          pend_nz;
  logic          frame_done;
  logic          hdr_fetch;

  txw_base_regs #(.AW(AW)) u_base (
    .clk   (clk),
    .rst   (rst),
    .lo_we (base_lo_we),
    .hi_we (base_hi_we),
    .wdata (cfg_wdata),
    .base  (base)
  );

  txw_pend_ctr #(.W(PEND_W)) u_pend (
    .clk (clk),
    .rst (rst),
    .clr (hold),
    .inc (doorbell),
    .dec (frame_done),
    .nz  (pend_nz)
  );

  txw_seq #(.AW(AW), .LINK_TYPE(LINK_TYPE)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .base       (base),
    .pend_nz    (pend_nz),
    .rd_req     (rd_req),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .frm_valid  (frm_valid),
    .frm_ready  (frm_ready),
    .frm_data   (frm_data),
    .frm_first  (frm_first),
    .frm_last   (frm_last),
    .link_evt   (link_evt),
    .frame_done (frame_done),
    .hdr_fetch  (hdr_fetch)
  );

  // R3: a record header is only fetched while frames are waiting
  p_hdr_work_r3: assert property (@(posedge clk) disable iff (rst || hold)
    (rd_req && hdr_fetch) |-> pend_nz);

  // R1: quiet ports straight out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_req && !frm_valid && !link_evt));

endmodule

// File: tb/tb_txw_walker.sv
module tb_txw_walker;
  localparam logic [63:0] BASE = 64'h0000_0003_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b1;
  logic        base_lo_we = 1'b0, base_hi_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        doorbell = 1'b0;
  logic        rd_req, rd_ready = 1'b0;
  logic [63:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        frm_valid, frm_ready = 1'b0;
  logic [31:0] frm_data;
  logic        frm_first, frm_last, link_evt;

  always #4 clk = ~clk;

  txw_walker dut (
    .clk(clk), .rst(rst), .hold(hold),
    .base_lo_we(base_lo_we), .base_hi_we(base_hi_we), .cfg_wdata(cfg_wdata),
    .doorbell(doorbell),
    .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_first(frm_first), .frm_last(frm_last), .link_evt(link_evt)
  );

  logic [31:0] mem [0:2047];
  logic [63:0] q_addr[$];
  bit          q_kind[$];
  logic [31:0] q_data[$];
  bit          q_first[$];
  bit          q_last[$];

  int n_chk = 0, n_err = 0;
  int mp = 0;
  int cyc = 0;
  int beats = 0, frames_done = 0, coinc = 0;
  bit mode = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory: one-cycle response to every accepted request
  initial forever begin
    @(posedge clk);
    rsp_valid <= rd_req && rd_ready;
    rsp_data  <= mem[rd_addr[12:2]];
  end

  // random handshake pressure
  initial forever begin
    @(negedge clk);
    rd_ready = ($urandom % 4) != 0;
    if (!mode) frm_ready = ($urandom % 3) != 0;
  end

  // cycle-by-cycle reference comparison
  initial forever begin
    @(negedge clk);
    #3;
    cyc++;
    if (cyc > 20000 && !done) begin
      n_err++;
      $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, 20000);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
    if (!rst) begin
      if (hold) begin
        q_addr.delete(); q_kind.delete(); q_data.delete();
        q_first.delete(); q_last.delete();
        mp = 0;
      end else begin
        if (mp == 0)
          chk(!rd_req && !frm_valid, "R3 idle with no waiting frame",
              {62'd0, rd_req, frm_valid}, 64'd0);
        if (rd_req && rd_ready) begin
          if (q_addr.size() == 0) chk(1'b0, "R5 unexpected read", rd_addr, 64'd0);
          else begin
            logic [63:0] ea;
            ea = q_addr.pop_front();
            chk(rd_addr == ea, "R2/R5/R6 read address", rd_addr, ea);
          end
        end
        if (link_evt) begin
          chk(q_kind.size() != 0 && q_kind[0] == 1'b1, "R6 link event order", 64'd1, 64'd1);
          if (q_kind.size() != 0 && q_kind[0]) begin
            void'(q_kind.pop_front()); void'(q_data.pop_front());
            void'(q_first.pop_front()); void'(q_last.pop_front());
          end
        end
        if (frm_valid && frm_ready) begin
          beats++;
          if (q_kind.size() == 0 || q_kind[0]) begin
            chk(1'b0, "R4 unexpected frame word (R6/R7)", {32'd0, frm_data}, 64'd0);
          end else begin
            logic [31:0] ed; bit ef, el;
            void'(q_kind.pop_front());
            ed = q_data.pop_front(); ef = q_first.pop_front(); el = q_last.pop_front();
            chk(frm_data == ed, "R4 frame word", {32'd0, frm_data}, {32'd0, ed});
            chk(frm_first == ef && frm_last == el, "R4 first/last flags",
                {62'd0, frm_first, frm_last}, {62'd0, ef, el});
          end
          if (frm_last) begin
            frames_done++;
            mp--;
            if (doorbell) coinc++;
          end
        end
        if (doorbell) mp++;
      end
    end
  end

  task automatic put_frame(input int off, input int sz, input logic [15:0] ty);
    int nw;
    nw = (sz == 0) ? 1 : (sz + 3) / 4;
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      w = (i == 0) ? {ty, sz[15:0]} : (32'hA500_0000 ^ 32'(off + 4 * i));
      mem[(off >> 2) + i] = w;
      q_addr.push_back(BASE + 64'(off + 4 * i));
      q_kind.push_back(1'b0); q_data.push_back(w);
      q_first.push_back(i == 0); q_last.push_back(i == nw - 1);
    end
  endtask

  task automatic put_link(input int off, input int tgt, input logic [1:0] lowbits);
    mem[off >> 2]       = {16'h1001, 16'd12};
    mem[(off >> 2) + 1] = BASE[31:0] + 32'(tgt) + {30'd0, lowbits};
    mem[(off >> 2) + 2] = BASE[63:32];
    for (int i = 0; i < 3; i++) q_addr.push_back(BASE + 64'(off + 4 * i));
    q_kind.push_back(1'b1); q_data.push_back('0); q_first.push_back(1'b0); q_last.push_back(1'b0);
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wr_base(input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk); base_lo_we = 1'b1; cfg_wdata = lo;
    @(negedge clk); base_lo_we = 1'b0; base_hi_we = 1'b1; cfg_wdata = hi;
    @(negedge clk); base_hi_we = 1'b0;
  endtask

  // accept only a final word, together with a doorbell pulse (R8)
  task automatic coincide();
    mode = 1'b1;
    forever begin
      @(negedge clk);
      if (frm_valid && frm_last) begin
        frm_ready = 1'b1; doorbell = 1'b1;
        break;
      end
      frm_ready = frm_valid;
    end
    @(negedge clk); frm_ready = 1'b0; doorbell = 1'b0; mode = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (q_kind.size() == 0 && !frm_valid) break;
    end
    chk(q_kind.size() == 0 && q_addr.size() == 0, "R4 all records delivered",
        64'(q_kind.size()), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!rd_req && !frm_valid && !link_evt, "R1 reset state",
        {61'd0, rd_req, frm_valid, link_evt}, 64'd0);
    wr_base(BASE[31:0] | 32'h3, BASE[63:32]);
    @(negedge clk); hold = 1'b0;
    repeat (20) @(negedge clk);
    #1 chk(!rd_req, "R1 no read without doorbell", {63'd0, rd_req}, 64'd0);

    // page 0 first lap, link to page 1, link back to page 0
    put_frame(16'h000, 6,  16'h0011);
    put_frame(16'h008, 4,  16'h0012);
    put_frame(16'h00C, 13, 16'h0013);
    put_frame(16'h01C, 1,  16'h0014);
    put_link (16'h020, 16'h800, 2'b01);
    put_frame(16'h800, 20, 16'h0015);
    put_link (16'h814, 16'h040, 2'b10);
    put_frame(16'h040, 0,  16'h0016);
    ring();
    repeat (10) @(negedge clk);
    ring(); ring();
    coincide();
    coincide();
    repeat (5) @(negedge clk);
    ring();
    drain();
    chk(frames_done == 6, "R7 frames delivered across links", 64'(frames_done), 64'd6);
    chk(coinc >= 2, "R8 doorbell with frame completion", 64'(coinc), 64'd2);
    repeat (30) @(negedge clk);
    #1 chk(!rd_req && !frm_valid, "R3 stall when drained", {62'd0, rd_req, frm_valid}, 64'd0);

    // consumer back-pressure
    put_frame(16'h044, 8, 16'h0017);
    mode = 1'b1; frm_ready = 1'b0;
    ring();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (frm_valid) break;
    end
    begin
      logic [31:0] d0;
      d0 = frm_data;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk); #1;
        chk(frm_valid && frm_data == d0 && frm_first && !rd_req, "R9 held under stall",
            {31'd0, frm_valid, frm_data}, {32'd1, d0});
      end
    end
    frm_ready = 1'b1; mode = 1'b0;
    drain();

    // abort mid-frame
    put_frame(16'h04C, 40, 16'h0018);
    ring(); ring();
    begin
      int b0;
      b0 = beats;
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (beats >= b0 + 3) break;
      end
    end
    hold = 1'b1;
    @(negedge clk); #1;
    chk(!frm_valid && !rd_req, "R10 abort quiets ports", {62'd0, frm_valid, rd_req}, 64'd0);
    wr_base(BASE[31:0] + 32'h100, BASE[63:32]);
    repeat (3) @(negedge clk);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    #1 chk(!rd_req && !frm_valid, "R10 waiting count cleared", {62'd0, rd_req, frm_valid}, 64'd0);
    put_frame(16'h100, 7, 16'h0019);
    ring();
    drain();
    chk(!frm_valid && !rd_req, "R2 restart from new start address", {62'd0, frm_valid, rd_req}, 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule